// File: doc/BRIEF.md
# Setpoint-Slewed Phase Tracking Detector

This block closes the digital part of a phase-locked loop that keeps a local oscillator aligned to a recovered receive clock. Two tag streams arrive: phase tags of the receive clock and phase tags of the local clock, both modulo one beat period of `2^TAG_W` counts. The block pairs one tag from each stream and forms the phase error. The error is the receive tag minus the local tag, less an applied phase offset. A proportional-integral controller turns that error into a signed tuning word for the local oscillator.

The phase offset requested by software is not applied in one step. The applied offset walks toward the requested value by one count per paired update, so the loop never sees a phase step. The error is not folded into a single beat period. A signed period counter follows every jump of more than half a period, so wander of several periods still gives a continuous error. Lock is judged on the average error over a programmable window of `2^win_log_i` updates. A large excursion whose mean is zero therefore does not drop lock.

Top module: `sp_phase_det`

## Requirements
- R1: While reset is asserted and right after it, `tune_o` is 0, `locked_o` is 0 and the applied offset is 0, so `sp_done_o` is 1 only when `sp_tgt_i` is 0.
- R2: A receive tag and a local tag form a pair in the cycle where the second of them arrives, in either order, or together in one cycle. `tune_o` shows the result of that pair three clock edges after the edge that samples the completing tag.
- R3: A tag left without a partner for TIMEOUT (default 64) idle cycles is dropped and never paired. The stream that dropped it then needs a new tag.
- R4: The raw error is `(rx_tag - local_tag - applied_offset) mod 2^TAG_W`, read as a two's-complement value in `[-2^(TAG_W-1), 2^(TAG_W-1))`.
- R5: A signed period counter (CNT_W bits, saturating) goes up by one when the raw error drops by more than `2^(TAG_W-1)` from the previous pair. It goes down by one when the raw error rises by more than that. The first pair after reset never changes it. The extended error is the raw error plus the counter times `2^TAG_W`.
- R6: On each pair, the applied offset moves one count toward `sp_tgt_i` (unsigned compare). The error of that pair uses the offset from before the step.
- R7: `sp_done_o` is 1 exactly when the applied offset equals `sp_tgt_i`.
- R8: On each pair the integrator adds `ki_i * e`, where `e` is the extended error. Then `tune_o = (kp_i * e + integrator) >>> OUT_SH`, and OUT_SH defaults to 0. `tune_o` holds between pairs.
- R9: After every `2^win_log_i` pairs, `locked_o` becomes 1 when the magnitude of the windowed sum shifted right arithmetically by `win_log_i` is at most `lk_thr_i`. Otherwise it becomes 0. It holds between window ends.
- R10: A window whose samples reach far beyond `lk_thr_i` but average to zero leaves `locked_o` at 1 for every sample in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_vld_i | input | 1 | Receive-clock tag strobe |
| rx_tag_i | input | TAG_W | Receive-clock phase tag |
| lc_vld_i | input | 1 | Local-clock tag strobe |
| lc_tag_i | input | TAG_W | Local-clock phase tag |
| sp_tgt_i | input | TAG_W | Requested phase offset |
| kp_i | input | GAIN_W | Proportional gain, unsigned |
| ki_i | input | GAIN_W | Integral gain, unsigned |
| win_log_i | input | WLOG_W | Log2 of the lock averaging window |
| lk_thr_i | input | TAG_W+CNT_W | Lock threshold on average error magnitude |
| tune_o | output | ACC_W | Signed oscillator tuning word |
| locked_o | output | 1 | Lock status |
| sp_done_o | output | 1 | Applied offset equals requested offset |

## Verification
With the proportional gain at one and the integral gain at zero, `tune_o` shows the extended error directly. A wrong period count therefore appears as a `tune_o` off by a whole multiple of `2^TAG_W`, three edges after the pair that crossed. A stale tag that is wrongly kept appears as a `tune_o` change when only one stream has delivered. A faulty offset ramp appears as an error sequence that does not step by exactly one count per pair, and as `sp_done_o` rising on the wrong pair. Lock faults can only show at a window end, so each lock check counts `2^win_log_i` pairs and looks at `locked_o` both inside a window and right after it ends.

// File: rtl/pd_pkg.sv
package pd_pkg;
    // Period-crossing decision for one pair
    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_UP   = 2'd1,
        WR_DN   = 2'd2
    } wrap_e;
endpackage

// File: rtl/pd_pair.sv
module pd_pair #(
    parameter int TAG_W   = 12,
    parameter int TIMEOUT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_vld_i,
    input  logic [TAG_W-1:0] rx_tag_i,
    input  logic             lc_vld_i,
    input  logic [TAG_W-1:0] lc_tag_i,
    output logic             pv_o,
    output logic [TAG_W-1:0] prx_o,
    output logic [TAG_W-1:0] plc_o
);
    localparam int AGE_W = $clog2(TIMEOUT + 1);
    localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(TIMEOUT - 1);

    typedef struct packed {
        logic             rx_p;
        logic             lc_p;
        logic [TAG_W-1:0] rx_t;
        logic [TAG_W-1:0] lc_t;
        logic [AGE_W-1:0] age;
        logic             pv;
        logic [TAG_W-1:0] prx;
        logic [TAG_W-1:0] plc;
    } st_t;

    st_t s_d, s_q;
    logic have_rx, have_lc;

    always_comb begin
        s_d     = s_q;
        s_d.pv  = 1'b0;
        have_rx = rx_vld_i | s_q.rx_p;
        have_lc = lc_vld_i | s_q.lc_p;
        if (rx_vld_i) s_d.rx_t = rx_tag_i;
        if (lc_vld_i) s_d.lc_t = lc_tag_i;
        if (have_rx && have_lc) begin
            s_d.pv   = 1'b1;
            s_d.prx  = rx_vld_i ? rx_tag_i : s_q.rx_t;
            s_d.plc  = lc_vld_i ? lc_tag_i : s_q.lc_t;
            s_d.rx_p = 1'b0;
            s_d.lc_p = 1'b0;
            s_d.age  = '0;
        end else if (rx_vld_i || lc_vld_i) begin
            s_d.rx_p = have_rx;
            s_d.lc_p = have_lc;
            s_d.age  = '0;
        end else if (s_q.rx_p || s_q.lc_p) begin
            if (s_q.age == AGE_LIM) begin
                s_d.rx_p = 1'b0;
                s_d.lc_p = 1'b0;
                s_d.age  = '0;
            end else begin
                s_d.age = s_q.age + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pv_o  = s_q.pv;
    assign prx_o = s_q.prx;
    assign plc_o = s_q.plc;

    // R3
    stale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rx_p && s_q.age == AGE_LIM && !rx_vld_i && !lc_vld_i) |=> !s_q.rx_p);

    // R2
    pair_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld_i && lc_vld_i) |=> pv_o);
endmodule

// File: rtl/pd_ramp.sv
module pd_ramp #(
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [TAG_W-1:0] tgt_i,
    output logic [TAG_W-1:0] app_o
);
    typedef struct packed {
        logic [TAG_W-1:0] app;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (step_i && (s_q.app != tgt_i)) begin
            if (tgt_i > s_q.app) s_d.app = s_q.app + 1'b1;
            else                 s_d.app = s_q.app - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign app_o = s_q.app;

    // R6
    ramp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(app_o));

    // R6
    ramp_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && app_o != tgt_i) |=> (app_o != $past(app_o)));

    // R7
    ramp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && app_o == tgt_i) |=> $stable(app_o));
endmodule

// File: rtl/pd_unwrap.sv
module pd_unwrap
    import pd_pkg::*;
#(
    parameter int TAG_W = 12,
    parameter int CNT_W = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            pv_i,
    input  logic        [TAG_W-1:0]         rx_i,
    input  logic        [TAG_W-1:0]         lc_i,
    input  logic        [TAG_W-1:0]         sp_i,
    output logic                            ev_o,
    output logic signed [TAG_W+CNT_W-1:0]   ext_o
);
    localparam int ERR_W = TAG_W + CNT_W;
    localparam logic signed [TAG_W:0]   HALF_P = (TAG_W+1)'(2 ** (TAG_W - 1));
    localparam logic signed [TAG_W:0]   HALF_N = -HALF_P;
    localparam logic signed [CNT_W-1:0] CMAX   = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic signed [CNT_W-1:0] CMIN   = {1'b1, {(CNT_W-1){1'b0}}};

    typedef struct packed {
        logic                     seen;
        logic signed [TAG_W-1:0]  prev;
        logic signed [CNT_W-1:0]  cnt;
        logic                     ev;
        logic signed [ERR_W-1:0]  ext;
    } st_t;

    st_t s_d, s_q;
    logic signed [TAG_W-1:0] raw;
    logic signed [TAG_W:0]   diff;
    wrap_e                   wr;

    always_comb begin
        s_d  = s_q;
        s_d.ev = 1'b0;
        raw  = $signed(rx_i - lc_i - sp_i);
        diff = (TAG_W+1)'(raw) - (TAG_W+1)'(s_q.prev);
        wr   = WR_NONE;
        if (s_q.seen) begin
            if (diff < HALF_N)      wr = WR_UP;
            else if (diff > HALF_P) wr = WR_DN;
        end
        if (pv_i) begin
            case (wr)
                WR_UP:   if (s_q.cnt != CMAX) s_d.cnt = s_q.cnt + 1'b1;
                WR_DN:   if (s_q.cnt != CMIN) s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
            s_d.seen = 1'b1;
            s_d.prev = raw;
            s_d.ev   = 1'b1;
            s_d.ext  = ERR_W'(raw) + $signed({s_d.cnt, {TAG_W{1'b0}}});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ev_o  = s_q.ev;
    assign ext_o = s_q.ext;

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((CNT_W+1)'(s_q.cnt) - (CNT_W+1)'($past(s_q.cnt)) <= (CNT_W+1)'(1)) &&
                 ((CNT_W+1)'(s_q.cnt) - (CNT_W+1)'($past(s_q.cnt)) >= -(CNT_W+1)'(1)));

    // R5
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pv_i |=> $stable(s_q.cnt));
endmodule

// File: rtl/pd_lock.sv
module pd_lock #(
    parameter int ERR_W  = 16,
    parameter int WLOG_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ev_i,
    input  logic signed [ERR_W-1:0] ext_i,
    input  logic [WLOG_W-1:0]       win_log_i,
    input  logic [ERR_W-1:0]        thr_i,
    output logic                    locked_o
);
    localparam int CW = (1 << WLOG_W) - 1;
    localparam int AW = ERR_W + CW + 1;

    typedef struct packed {
        logic signed [AW-1:0] acc;
        logic [CW-1:0]        cnt;
        logic                 locked;
    } st_t;

    st_t s_d, s_q;
    logic signed [AW-1:0] acc_n, avg, mag;
    logic [CW-1:0]        last;

    always_comb begin
        s_d   = s_q;
        last  = CW'((32'd1 << win_log_i) - 32'd1);
        acc_n = s_q.acc + AW'(ext_i);
        avg   = acc_n >>> win_log_i;
        mag   = avg[AW-1] ? -avg : avg;
        if (ev_i) begin
            if (s_q.cnt == last) begin
                s_d.locked = ($unsigned(mag) <= AW'(thr_i));
                s_d.acc    = '0;
                s_d.cnt    = '0;
            end else begin
                s_d.acc = acc_n;
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign locked_o = s_q.locked;

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_i |=> $stable(locked_o));

    // R9
    win_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i && s_q.cnt != last) |=> $stable(locked_o));
endmodule

// File: rtl/sp_phase_det.sv
module sp_phase_det #(
    parameter int TAG_W   = 12,
    parameter int CNT_W   = 4,
    parameter int GAIN_W  = 8,
    parameter int ACC_W   = 32,
    parameter int OUT_SH  = 0,
    parameter int WLOG_W  = 3,
    parameter int TIMEOUT = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rx_vld_i,
    input  logic [TAG_W-1:0]          rx_tag_i,
    input  logic                      lc_vld_i,
    input  logic [TAG_W-1:0]          lc_tag_i,
    input  logic [TAG_W-1:0]          sp_tgt_i,
    input  logic [GAIN_W-1:0]         kp_i,
    input  logic [GAIN_W-1:0]         ki_i,
    input  logic [WLOG_W-1:0]         win_log_i,
    input  logic [TAG_W+CNT_W-1:0]    lk_thr_i,
    output logic signed [ACC_W-1:0]   tune_o,
    output logic                      locked_o,
    output logic                      sp_done_o
);
    localparam int ERR_W = TAG_W + CNT_W;

    logic                    pv;
    logic [TAG_W-1:0]        prx, plc, sp_app;
    logic                    ev;
    logic signed [ERR_W-1:0] ext;

    pd_pair #(.TAG_W(TAG_W), .TIMEOUT(TIMEOUT)) u_pair (
        .clk(clk), .rst_n(rst_n),
        .rx_vld_i(rx_vld_i), .rx_tag_i(rx_tag_i),
        .lc_vld_i(lc_vld_i), .lc_tag_i(lc_tag_i),
        .pv_o(pv), .prx_o(prx), .plc_o(plc)
    );

    pd_ramp #(.TAG_W(TAG_W)) u_ramp (
        .clk(clk), .rst_n(rst_n),
        .step_i(pv), .tgt_i(sp_tgt_i), .app_o(sp_app)
    );

    pd_unwrap #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_unwrap (
        .clk(clk), .rst_n(rst_n),
        .pv_i(pv), .rx_i(prx), .lc_i(plc), .sp_i(sp_app),
        .ev_o(ev), .ext_o(ext)
    );

    pd_lock #(.ERR_W(ERR_W), .WLOG_W(WLOG_W)) u_lock (
        .clk(clk), .rst_n(rst_n),
        .ev_i(ev), .ext_i(ext), .win_log_i(win_log_i), .thr_i(lk_thr_i),
        .locked_o(locked_o)
    );

    // Proportional-integral stage
    typedef struct packed {
        logic signed [ACC_W-1:0] integ;
        logic signed [ACC_W-1:0] tune;
    } st_t;

    st_t s_d, s_q;
    logic signed [ACC_W-1:0] p_kp, p_ki;

    always_comb begin
        s_d  = s_q;
        p_kp = ACC_W'($signed({1'b0, kp_i})) * ACC_W'(ext);
        p_ki = ACC_W'($signed({1'b0, ki_i})) * ACC_W'(ext);
        if (ev) begin
            s_d.integ = s_q.integ + p_ki;
            s_d.tune  = (p_kp + s_d.integ) >>> OUT_SH;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tune_o    = s_q.tune;
    assign sp_done_o = (sp_app == sp_tgt_i);

    // R8
    tune_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev |=> $stable(tune_o));

    // R1
    reset_val_chk: assert property (@(posedge clk)
        !rst_n |=> (tune_o == '0 || rst_n));
endmodule

// File: tb/sim_sp_phase_det.sv
module sim_sp_phase_det;
    localparam int TAG_W = 12;
    localparam int CNT_W = 4;
    localparam int TMO   = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_vld = 1'b0, lc_vld = 1'b0;
    logic [TAG_W-1:0]  rx_tag = '0, lc_tag = '0, sp_tgt = '0;
    logic [7:0]        kp = 8'd1, ki = 8'd0;
    logic [2:0]        win_log = 3'd2;
    logic [TAG_W+CNT_W-1:0] thr = 16'd100;
    logic signed [31:0] tune;
    logic              locked, sp_done;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sp_phase_det u0 (
        .clk(clk), .rst_n(rst_n),
        .rx_vld_i(rx_vld), .rx_tag_i(rx_tag),
        .lc_vld_i(lc_vld), .lc_tag_i(lc_tag),
        .sp_tgt_i(sp_tgt), .kp_i(kp), .ki_i(ki),
        .win_log_i(win_log), .lk_thr_i(thr),
        .tune_o(tune), .locked_o(locked), .sp_done_o(sp_done)
    );

    // rx tag, local tag, expected extended error (kp=1, ki=0)
    localparam int NV = 10;
    localparam int VEC [NV][3] = '{
        '{100, 100, 0},    '{300, 100, 200},  '{1900, 0, 1900},
        '{2100, 0, 2100},  '{3000, 0, 3000},  '{100, 0, 4196},
        '{2200, 0, 2200},  '{1000, 0, 1000},  '{0, 2000, 2096},
        '{0, 100, 3996}
    };

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Both tags in one cycle; returns at the negedge after the third edge
    task automatic upd(input int r, input int l);
        rx_vld = 1'b1; lc_vld = 1'b1;
        rx_tag = TAG_W'(r); lc_tag = TAG_W'(l);
        @(negedge clk);
        rx_vld = 1'b0; lc_vld = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state, target nonzero during reset
        sp_tgt = 12'd7;
        repeat (3) @(negedge clk);
        chk("R1 tune in reset", tune, 0);
        chk("R1 locked in reset", locked, 0);
        chk("R7 done with target 7", sp_done, 0);
        sp_tgt = 12'd0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done with target 0", sp_done, 1);

        // R4 R5: vector table, tune equals extended error
        for (int i = 0; i < NV; i++) begin
            upd(VEC[i][0], VEC[i][1]);
            chk($sformatf("R5 R4 vector %0d", i), tune, VEC[i][2]);
        end

        // R6 R7: offset ramp up then down
        do_reset();
        sp_tgt = 12'd5;
        @(negedge clk);
        chk("R7 done after new target", sp_done, 0);
        for (int k = 1; k <= 5; k++) begin
            upd(0, 0);
            chk($sformatf("R6 ramp up pair %0d", k), tune, -(k - 1));
            if (k == 4) chk("R7 not done at 4", sp_done, 0);
            if (k == 5) chk("R7 done at 5", sp_done, 1);
        end
        upd(0, 0);
        chk("R6 ramp settled", tune, -5);
        sp_tgt = 12'd3;
        @(negedge clk);
        upd(0, 0);
        chk("R6 ramp down first", tune, -5);
        upd(0, 0);
        chk("R6 ramp down second", tune, -4);
        chk("R7 done at 3", sp_done, 1);
        upd(0, 0);
        chk("R6 ramp down settled", tune, -3);

        // R8: proportional-integral
        do_reset();
        sp_tgt = 12'd0;
        kp = 8'd2; ki = 8'd1;
        upd(10, 0);
        chk("R8 pi first", tune, 30);
        upd(20, 0);
        chk("R8 pi second", tune, 70);
        @(negedge clk);
        chk("R8 hold between pairs", tune, 70);
        kp = 8'd0;
        upd(5, 0);
        chk("R8 integral only", tune, 35);

        // R2 R3: timeout of a lone tag, then split pairing
        do_reset();
        kp = 8'd1; ki = 8'd0;
        upd(50, 0);
        chk("R2 simultaneous pair", tune, 50);
        rx_vld = 1'b1; rx_tag = 12'd1000;
        @(negedge clk);
        rx_vld = 1'b0;
        repeat (TMO + 6) @(negedge clk);
        lc_vld = 1'b1; lc_tag = 12'd0;
        @(negedge clk);
        lc_vld = 1'b0;
        repeat (5) @(negedge clk);
        chk("R3 stale tag dropped", tune, 50);
        rx_vld = 1'b1; rx_tag = 12'd60;
        @(negedge clk);
        rx_vld = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 local first then rx", tune, 60);

        // R9 R10: lock window of four
        do_reset();
        win_log = 3'd2; thr = 16'd100;
        for (int k = 0; k < 4; k++) begin
            upd((k % 2 == 0) ? 900 : 0, (k % 2 == 0) ? 0 : 900);
            if (k < 3) chk("R9 no decision mid window", locked, 0);
        end
        chk("R9 zero mean locks", locked, 1);
        for (int k = 0; k < 4; k++) begin
            upd((k % 2 == 0) ? 900 : 0, (k % 2 == 0) ? 0 : 900);
            chk($sformatf("R10 wander sample %0d", k), locked, 1);
        end
        for (int k = 0; k < 4; k++) upd(100, 0);
        chk("R9 average at threshold", locked, 1);
        for (int k = 0; k < 3; k++) upd(101, 0);
        chk("R9 held until window end", locked, 1);
        upd(101, 0);
        chk("R9 average above threshold", locked, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule